// File: doc/BRIEF.md
# TDM Time Slot Assigner Sequencer

This block routes the bit times of a serial time-division-multiplexed frame to a small set of serial channels. It walks a programmable table of routing entries, starting again at entry 0 on every frame sync. Each entry covers a run of consecutive bit times. For that run it raises one of four channel enables, drives a four-bit strobe mask, or does both. The receive and transmit directions each have their own table and their own sequencer. A common-sync control makes the transmit sequencer start on the receive sync, so identical tables give identical routing in both directions.

Each direction's table has two banks. In static mode the sequencer reads bank 0. Writes to either bank are taken at any time. In dynamic mode one bank is active and the other is a shadow. The host rewrites the shadow and then requests a swap. The swap happens only at the next frame sync of that direction and is confirmed by a one-cycle acknowledge. While dynamic mode is on, writes aimed at the active bank are dropped, so a frame in progress is never disturbed.

One clock cycle is one bit time. A sync sampled high at a clock edge makes the next cycle bit 0 of the frame.

Top module: `tsa_slot_seq`

## Requirements
- R1: After reset, all channel enables, strobes, entry indices, bank indicators and acknowledges are 0, and every table entry reads as zero.
- R2: An entry word is 13 bits: bit 12 is the last flag, bit 11 is the byte-unit flag, bits 10:7 are the count, bits 6:4 are the channel code and bits 3:0 are the strobe mask. With the byte-unit flag at 0 the entry lasts count+1 bit times.
- R3: With the byte-unit flag at 1 the entry lasts 8*(count+1) bit times.
- R4: Channel code 1, 2, 3 or 4 raises channel enable bit 0, 1, 2 or 3 respectively. Codes 0, 5, 6 and 7 raise none. At most one enable bit is ever high.
- R5: The strobe output equals the entry's strobe mask for every bit time of the entry, independent of the channel enable.
- R6: A sync sampled at a clock edge starts entry 0 in the following cycle. The index output shows the entry that drives the current bit, and it never changes except by stepping up by one or returning to 0.
- R7: After the entry with the last flag set (or after the final table slot when no entry has it), the enables and strobes stay 0 and the index reads 0 until the next sync.
- R8: A sync that arrives during a frame restarts the sequence at entry 0 in the next cycle.
- R9: With common sync set, the transmit sequencer starts on the receive sync. With it clear, each direction starts only on its own sync.
- R10: In dynamic mode, a swap request flips the active bank of each direction at that direction's next sync. The bank output changes only then, and the acknowledge pulses for exactly one cycle, the cycle of bit 0. A request made in static mode is dropped.
- R11: In dynamic mode, a host write to a direction's active bank is ignored and a write to its shadow bank is stored. In static mode, the sequencers read bank 0 and the bank outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_rx | input | 1 | Receive frame sync pulse |
| sync_tx | input | 1 | Transmit frame sync pulse |
| common_sync | input | 1 | Transmit sequencer uses the receive sync |
| dyn_mode | input | 1 | Enables active/shadow bank operation |
| swap_req | input | 1 | Requests a bank swap at the next sync |
| wr_en | input | 1 | Host table write strobe |
| wr_dir | input | 1 | Write target: 0 receive, 1 transmit |
| wr_bank | input | 1 | Write target bank |
| wr_addr | input | AW | Write target entry |
| wr_data | input | 13 | Entry word (R2 layout) |
| chan_en_rx | output | 4 | Receive channel enables |
| strb_rx | output | 4 | Receive strobes |
| idx_rx | output | AW | Receive current entry index |
| bank_rx | output | 1 | Receive active bank |
| swap_ack_rx | output | 1 | Receive swap acknowledge pulse |
| chan_en_tx | output | 4 | Transmit channel enables |
| strb_tx | output | 4 | Transmit strobes |
| idx_tx | output | AW | Transmit current entry index |
| bank_tx | output | 1 | Transmit active bank |
| swap_ack_tx | output | 1 | Transmit swap acknowledge pulse |

## Verification
A wrong run counter shows as an entry boundary that lands early or late. It first appears at the first bit where the enables or the index move in the wrong cycle, which is at most 128 bit times after the entry starts. A wrong bank register or lost swap request shows as a frame that follows the wrong table from bit 0, with the acknowledge missing or misplaced in that same cycle. Every cycle of every frame is compared against a table walk computed in the bench, so a fault in the stop logic shows on the first idle cycle after the last entry.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   localparam int CH_N   = 4;
   localparam int STRB_W = 4;
   localparam int CODE_W = 3;
   localparam int CNT_W  = 4;
   localparam int ENT_W  = 2 + CNT_W + CODE_W + STRB_W;
   localparam int REM_W  = CNT_W + 3;

   typedef struct packed {
      logic              lst;
      logic              byt;
      logic [CNT_W-1:0]  cnt;
      logic [CODE_W-1:0] chan;
      logic [STRB_W-1:0] strb;
   } tsa_entry_t;

   function automatic logic [CH_N-1:0] chan_decode(input logic [CODE_W-1:0] c);
      logic [CH_N-1:0] r;
      r = '0;
      if (c != '0 && int'(c) <= CH_N) r[int'(c) - 1] = 1'b1;
      return r;
   endfunction

   function automatic logic [REM_W-1:0] run_init(input tsa_entry_t e);
      return e.byt ? {e.cnt, 3'b111} : {3'b000, e.cnt};
   endfunction
endpackage

// File: rtl/tsa_table.sv
module tsa_table
   import tsa_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int NB    = 2,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          wbank,
   input  logic [AW-1:0] waddr,
   input  tsa_entry_t    wdata,
   input  logic          rbank,
   input  logic [AW-1:0] raddr,
   output tsa_entry_t    rdata
);
   tsa_entry_t mem [NB*DEPTH];

   logic wsel, rsel;
   assign wsel = (NB > 1) ? wbank : 1'b0;
   assign rsel = (NB > 1) ? rbank : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NB*DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[{wsel, waddr}] <= wdata;
      end
   end

   assign rdata = mem[{rsel, raddr}];
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
   import tsa_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter bit DYN_EN = 1'b1,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              dyn_mode,
   input  logic              swap_req,
   input  tsa_entry_t        rd_data,
   output logic              rd_bank,
   output logic [AW-1:0]     rd_addr,
   output logic [CH_N-1:0]   chan_en,
   output logic [STRB_W-1:0] strb,
   output logic [AW-1:0]     idx,
   output logic              bank_o,
   output logic              ack
);
   logic             running;
   logic [AW-1:0]    idx_q;
   logic [REM_W-1:0] rem_q;
   tsa_entry_t       cur_q;
   logic             bank_q, ack_q, swap_now;
   logic             eff_bank;

   generate
      if (DYN_EN) begin : g_dyn
         logic pend_q;
         assign swap_now = dyn_mode && pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bank_q <= 1'b0;
               pend_q <= 1'b0;
               ack_q  <= 1'b0;
            end else begin
               ack_q <= 1'b0;
               if (sync && swap_now) begin
                  bank_q <= ~bank_q;
                  ack_q  <= 1'b1;
               end
               if (dyn_mode && swap_req)  pend_q <= 1'b1;
               else if (sync && swap_now) pend_q <= 1'b0;
            end
         end
      end else begin : g_static
         logic unused_swap;
         assign unused_swap = swap_req;
         assign swap_now    = 1'b0;
         assign bank_q      = 1'b0;
         assign ack_q       = 1'b0;
      end
   endgenerate

   assign eff_bank = dyn_mode & bank_q;
   assign rd_bank  = (sync && swap_now) ? ~bank_q : eff_bank;
   assign rd_addr  = sync ? '0 : idx_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         idx_q   <= '0;
         rem_q   <= '0;
         cur_q   <= '0;
      end else if (sync) begin
         running <= 1'b1;
         idx_q   <= '0;
         cur_q   <= rd_data;
         rem_q   <= run_init(rd_data);
      end else if (running) begin
         if (rem_q == '0) begin
            if (cur_q.lst || idx_q == AW'(DEPTH-1)) begin
               running <= 1'b0;
               idx_q   <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
               cur_q <= rd_data;
               rem_q <= run_init(rd_data);
            end
         end else begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign chan_en = running ? chan_decode(cur_q.chan) : '0;
   assign strb    = running ? cur_q.strb : '0;
   assign idx     = idx_q;
   assign bank_o  = eff_bank;
   assign ack     = ack_q;
endmodule

// File: rtl/tsa_slot_seq.sv
module tsa_slot_seq
   import tsa_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter bit DYN_EN = 1'b1,
   localparam int AW    = $clog2(DEPTH),
   localparam int NB    = DYN_EN ? 2 : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_rx,
   input  logic              sync_tx,
   input  logic              common_sync,
   input  logic              dyn_mode,
   input  logic              swap_req,
   input  logic              wr_en,
   input  logic              wr_dir,
   input  logic              wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [ENT_W-1:0]  wr_data,
   output logic [CH_N-1:0]   chan_en_rx,
   output logic [STRB_W-1:0] strb_rx,
   output logic [AW-1:0]     idx_rx,
   output logic              bank_rx,
   output logic              swap_ack_rx,
   output logic [CH_N-1:0]   chan_en_tx,
   output logic [STRB_W-1:0] strb_tx,
   output logic [AW-1:0]     idx_tx,
   output logic              bank_tx,
   output logic              swap_ack_tx
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tsa_slot_seq: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [1:0]                  sync_d, we_d, rbank_d, bank_d, ack_d;
   logic [1:0][AW-1:0]          raddr_d, idx_d;
   logic [1:0][CH_N-1:0]        chan_d;
   logic [1:0][STRB_W-1:0]      strb_d;
   tsa_entry_t                  rdata_d [2];

   assign sync_d[0] = sync_rx;
   assign sync_d[1] = common_sync ? sync_rx : sync_tx;

   for (genvar d = 0; d < 2; d++) begin : g_dir
      assign we_d[d] = wr_en && (wr_dir == d[0])
                     && !(DYN_EN && dyn_mode && (wr_bank == bank_d[d]));

      tsa_table #(.DEPTH(DEPTH), .NB(NB)) u_tbl (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we_d[d]),
         .wbank (wr_bank),
         .waddr (wr_addr),
         .wdata (tsa_entry_t'(wr_data)),
         .rbank (rbank_d[d]),
         .raddr (raddr_d[d]),
         .rdata (rdata_d[d])
      );

      tsa_seq #(.DEPTH(DEPTH), .DYN_EN(DYN_EN)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync     (sync_d[d]),
         .dyn_mode (dyn_mode),
         .swap_req (swap_req),
         .rd_data  (rdata_d[d]),
         .rd_bank  (rbank_d[d]),
         .rd_addr  (raddr_d[d]),
         .chan_en  (chan_d[d]),
         .strb     (strb_d[d]),
         .idx      (idx_d[d]),
         .bank_o   (bank_d[d]),
         .ack      (ack_d[d])
      );
   end

   assign chan_en_rx  = chan_d[0];
   assign strb_rx     = strb_d[0];
   assign idx_rx      = idx_d[0];
   assign bank_rx     = bank_d[0];
   assign swap_ack_rx = ack_d[0];
   assign chan_en_tx  = chan_d[1];
   assign strb_tx     = strb_d[1];
   assign idx_tx      = idx_d[1];
   assign bank_tx     = bank_d[1];
   assign swap_ack_tx = ack_d[1];
endmodule

// File: rtl/tsa_slot_seq_chk.sv
module tsa_slot_seq_chk #(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_rx,
   input logic          dyn_mode,
   input logic [3:0]    chan_en_rx,
   input logic [3:0]    chan_en_tx,
   input logic [AW-1:0] idx_rx,
   input logic          bank_rx,
   input logic          swap_ack_rx
);
   // R4: never two channels at once
   a_r4_onehot_rx: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_en_rx));
   a_r4_onehot_tx: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_en_tx));

   // R6: sync starts entry 0
   a_r6_sync_idx: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rx |=> (idx_rx == '0));

   // R6: index only steps up or returns to 0
   a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (idx_rx == $past(idx_rx) || idx_rx == AW'($past(idx_rx) + 1'b1)
                || idx_rx == '0));

   // R10: acknowledge only right after a sync, with a bank change
   a_r10_ack_sync: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ack_rx |-> $past(sync_rx));
   a_r10_ack_flip: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ack_rx |-> (bank_rx != $past(bank_rx)));

   // R10: bank holds between syncs while dynamic mode stays on
   a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dyn_mode && !sync_rx) ##1 dyn_mode |-> $stable(bank_rx));
endmodule

bind tsa_slot_seq tsa_slot_seq_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_rx     (sync_rx),
   .dyn_mode    (dyn_mode),
   .chan_en_rx  (chan_en_rx),
   .chan_en_tx  (chan_en_tx),
   .idx_rx      (idx_rx),
   .bank_rx     (bank_rx),
   .swap_ack_rx (swap_ack_rx)
);

// File: tb/tsa_slot_seq_tb.sv
module tsa_slot_seq_tb;
   localparam int DEPTH = 8;
   localparam int AW    = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, sync_rx, sync_tx, common_sync, dyn_mode, swap_req;
   logic wr_en, wr_dir, wr_bank;
   logic [AW-1:0] wr_addr;
   logic [12:0]   wr_data;
   logic [3:0]    chan_en_rx, strb_rx, chan_en_tx, strb_tx;
   logic [AW-1:0] idx_rx, idx_tx;
   logic          bank_rx, bank_tx, swap_ack_rx, swap_ack_tx;

   tsa_slot_seq #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_rx(sync_rx), .sync_tx(sync_tx),
      .common_sync(common_sync), .dyn_mode(dyn_mode), .swap_req(swap_req),
      .wr_en(wr_en), .wr_dir(wr_dir), .wr_bank(wr_bank), .wr_addr(wr_addr),
      .wr_data(wr_data),
      .chan_en_rx(chan_en_rx), .strb_rx(strb_rx), .idx_rx(idx_rx),
      .bank_rx(bank_rx), .swap_ack_rx(swap_ack_rx),
      .chan_en_tx(chan_en_tx), .strb_tx(strb_tx), .idx_tx(idx_tx),
      .bank_tx(bank_tx), .swap_ack_tx(swap_ack_tx)
   );

   int vectors = 0, miscompares = 0;
   bit done = 0;
   logic [12:0] mdl [2][2][DEPTH];
   int pos [2];
   int exp_bank [2];
   bit pend [2];
   bit ack_exp [2];

   function automatic logic [12:0] mk(bit lst, bit byt, int cnt, int chan, int strb);
      return {lst, byt, 4'(cnt), 3'(chan), 4'(strb)};
   endfunction

   function automatic logic [3:0] dec(logic [2:0] c);
      case (c)
         3'd1: return 4'b0001;
         3'd2: return 4'b0010;
         3'd3: return 4'b0100;
         3'd4: return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic chk(int d, string tag);
      logic [3:0] ech = 0, est = 0, ach, ast;
      int eix = 0, acc = 0, len;
      bit stop = 0;
      logic [AW-1:0] aix;
      logic ab, aa, eb;
      logic [12:0] e;
      int rb = dyn_mode ? exp_bank[d] : 0;
      if (pos[d] >= 0) begin
         for (int i = 0; i < DEPTH && !stop; i++) begin
            e   = mdl[d][rb][i];
            len = e[11] ? (int'(e[10:7]) + 1) * 8 : int'(e[10:7]) + 1;
            if (pos[d] < acc + len) begin
               ech = dec(e[6:4]); est = e[3:0]; eix = i; stop = 1;
            end else begin
               acc += len;
               if (e[12]) stop = 1;
            end
         end
      end
      eb  = rb[0];
      ach = d == 0 ? chan_en_rx : chan_en_tx;
      ast = d == 0 ? strb_rx    : strb_tx;
      aix = d == 0 ? idx_rx     : idx_tx;
      ab  = d == 0 ? bank_rx    : bank_tx;
      aa  = d == 0 ? swap_ack_rx : swap_ack_tx;
      vectors++;
      if ({ach, ast, aix, ab, aa} !== {ech, est, AW'(eix), eb, ack_exp[d]}) begin
         miscompares++;
         $display("FAIL %s dir=%0d pos=%0d actual ch=%b st=%b ix=%0d bk=%b ack=%b expected ch=%b st=%b ix=%0d bk=%b ack=%b",
                  tag, d, pos[d], ach, ast, aix, ab, aa, ech, est, eix, eb, ack_exp[d]);
      end
      ack_exp[d] = 0;
   endtask

   task automatic tick();
      for (int d = 0; d < 2; d++) if (pos[d] >= 0) pos[d]++;
      @(negedge clk);
   endtask

   task automatic steps(int n, string tag);
      for (int k = 0; k < n; k++) begin
         chk(0, tag);
         chk(1, tag);
         tick();
      end
   endtask

   task automatic start(bit srx, bit stx);
      bit rs;
      sync_rx = srx; sync_tx = stx;
      @(negedge clk);
      sync_rx = 0; sync_tx = 0;
      for (int d = 0; d < 2; d++) begin
         rs = d == 0 ? srx : (common_sync ? srx : stx);
         if (rs) begin
            pos[d] = 0;
            if (dyn_mode && pend[d]) begin
               exp_bank[d] ^= 1; ack_exp[d] = 1; pend[d] = 0;
            end
         end else if (pos[d] >= 0) pos[d]++;
      end
   endtask

   task automatic wr(int d, int b, int a, logic [12:0] v);
      wr_en = 1; wr_dir = d[0]; wr_bank = b[0]; wr_addr = AW'(a); wr_data = v;
      tick();
      wr_en = 0;
      if (!(dyn_mode && b == exp_bank[d])) mdl[d][b][a] = v;
   endtask

   task automatic swap();
      swap_req = 1;
      tick();
      swap_req = 0;
      if (dyn_mode) begin pend[0] = 1; pend[1] = 1; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sync_rx = 0; sync_tx = 0; common_sync = 1; dyn_mode = 0;
      swap_req = 0; wr_en = 0; wr_dir = 0; wr_bank = 0; wr_addr = '0; wr_data = '0;
      for (int d = 0; d < 2; d++) begin
         pos[d] = -1; exp_bank[d] = 0; pend[d] = 0; ack_exp[d] = 0;
         for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) mdl[d][b][a] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      steps(2, "R1 reset state");

      // R9 common sync with identical tables; R6 start; R5 strobes
      for (int d = 0; d < 2; d++) begin
         wr(d, 0, 0, mk(0, 0, 7, 2, 0));
         wr(d, 0, 1, mk(0, 0, 0, 1, 1));
         wr(d, 0, 2, mk(0, 0, 0, 0, 0));
         wr(d, 0, 3, mk(0, 0, 3, 0, 2));
         wr(d, 0, 4, mk(0, 0, 3, 4, 0));
         wr(d, 0, 5, mk(1, 0, 0, 1, 1));
      end
      start(1, 0);
      steps(24, "R6 R9 R5 frame");

      // R8 early sync
      start(1, 0);
      steps(5, "R8 before restart");
      start(1, 0);
      steps(24, "R8 restarted frame");

      // R3 R4 R5 byte units, channel 3, unused codes
      wr(0, 0, 0, mk(0, 1, 1, 3, 4'b1000));
      wr(0, 0, 1, mk(0, 0, 2, 5, 4'b0101));
      wr(0, 0, 2, mk(0, 0, 1, 6, 4'b1111));
      wr(0, 0, 3, mk(1, 1, 0, 7, 0));
      start(1, 0);
      steps(34, "R3 R4 R5 mixed units");

      // R2 R3 length sweep over every count and unit
      for (int byt = 0; byt < 2; byt++)
         for (int c = 0; c < 16; c++) begin
            wr(0, 0, 0, mk(1, byt[0], c, c % 5, c));
            start(1, 0);
            steps(byt ? (c + 1) * 8 + 2 : c + 3, byt ? "R3 byte length" : "R2 bit length");
         end

      // R4 channel code sweep
      for (int c = 0; c < 8; c++) begin
         wr(0, 0, 0, mk(1, 0, 2, c, c));
         start(1, 0);
         steps(5, "R4 channel code");
      end

      // R7 table without a last flag stops after the final slot
      for (int i = 0; i < DEPTH; i++) wr(0, 0, i, mk(0, 0, i % 2, (i % 4) + 1, 1 << (i % 4)));
      start(1, 0);
      steps(16, "R7 end of table");

      // R9 separate syncs
      common_sync = 0;
      tick();
      start(1, 0);
      steps(6, "R9 rx sync only");
      start(0, 1);
      steps(25, "R9 tx own sync");
      common_sync = 1;

      // R11 R10 dynamic mode
      dyn_mode = 1;
      tick();
      wr(0, 1, 0, mk(0, 0, 1, 4, 2));
      wr(0, 1, 1, mk(1, 0, 2, 3, 1));
      wr(0, 0, 0, mk(1, 0, 0, 1, 0));
      start(1, 0);
      steps(16, "R11 active write ignored");
      swap();
      steps(3, "R10 bank held before sync");
      start(1, 0);
      steps(12, "R10 swap at sync");
      wr(0, 0, 0, mk(1, 0, 5, 2, 8));
      wr(0, 1, 0, mk(1, 0, 0, 0, 0));
      start(1, 0);
      steps(10, "R11 shadow write stored");
      dyn_mode = 0;
      tick();
      start(1, 0);
      steps(10, "R11 static reads bank 0");
      swap();
      dyn_mode = 1;
      tick();
      start(1, 0);
      steps(10, "R10 static request dropped");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule